// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block turns the pixel and line strobes of a display timing generator into the byte addresses that a fetch engine reads from a linear framebuffer of 16-bit pixels. Each stored line starts at the frame base plus a multiple of the line stride. Within a line the address steps by two bytes per stored pixel. The stored frame can be smaller than the visible raster. A flag tells downstream logic whether the current raster position lies inside the stored image.

Two display options change how the raster maps onto the stored frame. The first is a 2x magnification, which shows every stored pixel twice along a line and every stored line twice. The second is a bottom-up order, which fetches the last stored line first and then moves back toward line zero. Both options use the same base-plus-stride arithmetic.

A frame-start strobe arms the block and reloads all counters. A line strobe moves to the next raster line. A pixel strobe moves to the next raster pixel. The address output is combinational from registered state, so it is valid in the cycle after the strobe that produced it.

Top module: `scan_addr_gen`

## Requirements
- R1: One cycle after `frame_start_i`, the block sits at raster pixel 0 of raster line 0. `addr_o` equals the aligned base, or the start of the last stored line when bottom-up order is selected.
- R2: Bit 0 of the base and bit 0 of the stride are ignored. `addr_o[0]` is always 0.
- R3: Without options, raster position (line n, pixel p) inside the frame gives `addr_o = base + n*stride + 2*p`, computed modulo 2^32.
- R4: `frame_dim_i[10:0]` is the stored width in pixels and `frame_dim_i[26:16]` is the stored line count. All other bits are ignored.
- R5: With zoom enabled, raster pixel p maps to stored pixel p/2. `addr_valid_o` is high only on even raster pixels, which are the first of each pair.
- R6: With zoom enabled, raster line n maps to stored line n/2. The second line of a pair repeats the address sequence of the first.
- R7: With bottom-up order, stored line s is fetched from `base + (H-1-s)*stride`, where H is the stored line count.
- R8: A raster pixel at or beyond the stored width drives `in_frame_o` and `addr_valid_o` low, and `addr_o` holds its last in-frame value.
- R9: A raster line at or beyond the stored line count drives `in_frame_o` and `addr_valid_o` low. Pixel strobes on that line leave `addr_o` unchanged.
- R10: After reset, and until the first frame start, `in_frame_o` and `addr_valid_o` are low, `addr_o` is 0, and pixel and line strobes have no effect.
- R11: Strobes that arrive in the same cycle are resolved by priority. Frame start beats line advance, and line advance beats pixel advance: the pixel position restarts at 0 on the new line.
- R12: A stored width or line count of zero keeps `in_frame_o` low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame start strobe |
| line_adv_i | input | 1 | Raster line advance strobe |
| pix_adv_i | input | 1 | Raster pixel advance strobe |
| base_addr_i | input | 32 | Frame base byte address |
| stride_i | input | 32 | Byte distance between first pixels of adjacent lines |
| frame_dim_i | input | 32 | Stored width [10:0], stored line count [26:16] |
| zoom_i | input | 1 | 2x pixel and line duplication |
| rev_scan_i | input | 1 | Bottom-up line order |
| addr_o | output | 32 | Fetch byte address |
| addr_valid_o | output | 1 | A new fetch is due at this raster position |
| in_frame_o | output | 1 | Raster position lies inside the stored frame |

## Verification
The internal state consists of the line base register, the two position counters and their duplication phases. A wrong line base shows on `addr_o` in the first cycle after the strobe that loaded it, offset by a whole multiple of the stride. A counter that steps one pixel too early or too late shows as a two-byte address error on the next raster pixel. In zoom mode it also shows as `addr_valid_o` falling on the wrong parity. A saturation fault at the frame edge shows as `in_frame_o` staying high past the stored width or line count, or as `addr_o` drifting while out of frame, on the first strobe beyond the boundary.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned DIM_W = 11;

  typedef struct packed {
    logic [DIM_W-1:0] lines;
    logic [DIM_W-1:0] width;
  } frame_dim_t;

  // width in [10:0], line count in [26:16]
  function automatic frame_dim_t get_dim(input logic [31:0] word);
    frame_dim_t d;
    d.width = word[DIM_W-1:0];
    d.lines = word[16+DIM_W-1:16];
    return d;
  endfunction
endpackage

// File: rtl/scan_axis_ctr.sv
module scan_axis_ctr #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic          zoom_i,
  input  logic [CW-1:0] count_i,
  output logic [CW-1:0] idx_o,
  output logic          first_o,
  output logic          inside_o,
  output logic          adv_o
);
  logic [CW-1:0] idx_q;
  logic          phase_q;
  logic          repeat_w;
  logic [CW:0]   idx_nx;

  assign repeat_w = zoom_i & ~phase_q;
  assign idx_nx   = {1'b0, idx_q} + (CW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= 1'b0;
    end else if (restart_i) begin
      idx_q   <= '0;
      phase_q <= 1'b0;
    end else if (step_i) begin
      if (repeat_w) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (idx_q < count_i) idx_q <= idx_q + CW'(1);
      end
    end
  end

  assign idx_o    = idx_q;
  assign first_o  = ~phase_q;
  assign inside_o = idx_q < count_i;
  // stored index moves and stays inside the frame
  assign adv_o    = step_i & ~restart_i & ~repeat_w & (idx_nx < {1'b0, count_i});

  // R1
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (idx_q == '0) && !phase_q);
  // R5
  phase_zoom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q) |-> $past(zoom_i));
endmodule

// File: rtl/scan_line_base.sv
module scan_line_base #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          adv_i,
  input  logic          rev_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [CW-1:0] lines_i,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_al, stride_al, last_off, init_val, base_q;
  logic          base_unused;

  assign base_unused = base_i[0] ^ stride_i[0];
  assign base_al     = {base_i[AW-1:1], 1'b0};
  assign stride_al   = {stride_i[AW-1:1], 1'b0};
  assign last_off    = (AW'(lines_i) - AW'(1)) * stride_al;
  assign init_val    = (rev_i && lines_i != '0) ? base_al + last_off : base_al;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_q <= '0;
    else if (init_i)  base_q <= init_val;
    else if (adv_i)   base_q <= rev_i ? base_q - stride_al : base_q + stride_al;
  end

  assign base_o = base_q;

  // R1
  fwd_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !rev_i) |=> base_q == $past(base_al));
  // R3
  fwd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !init_i && !rev_i) |=> base_q == $past(base_q) + $past(stride_al));
  // R7
  rev_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !init_i && rev_i) |=> base_q == $past(base_q) - $past(stride_al));
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
  import scan_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          line_adv_i,
  input  logic          pix_adv_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [AW-1:0] stride_i,
  input  logic [31:0]   frame_dim_i,
  input  logic          zoom_i,
  input  logic          rev_scan_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_valid_o,
  output logic          in_frame_o
);
  localparam int unsigned CW = DIM_W;

  frame_dim_t    dims;
  logic          dim_unused;
  logic          active_q;
  logic [CW-1:0] row_idx, col_idx, col_sel;
  logic          row_first, row_inside, row_adv;
  logic          col_first, col_inside, col_adv;
  logic [AW-1:0] line_base;

  assign dims       = get_dim(frame_dim_i);
  assign dim_unused = ^{frame_dim_i[31:16+CW], frame_dim_i[15:CW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            active_q <= 1'b0;
    else if (frame_start_i) active_q <= 1'b1;
  end

  scan_axis_ctr #(.CW(CW)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (frame_start_i),
    .step_i    (line_adv_i & active_q),
    .zoom_i    (zoom_i),
    .count_i   (dims.lines),
    .idx_o     (row_idx),
    .first_o   (row_first),
    .inside_o  (row_inside),
    .adv_o     (row_adv)
  );

  // pixels freeze on lines outside the frame
  scan_axis_ctr #(.CW(CW)) u_col (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (frame_start_i | line_adv_i),
    .step_i    (pix_adv_i & active_q & row_inside),
    .zoom_i    (zoom_i),
    .count_i   (dims.width),
    .idx_o     (col_idx),
    .first_o   (col_first),
    .inside_o  (col_inside),
    .adv_o     (col_adv)
  );

  scan_line_base #(.AW(AW), .CW(CW)) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (frame_start_i),
    .adv_i    (row_adv),
    .rev_i    (rev_scan_i),
    .base_i   (base_addr_i),
    .stride_i (stride_i),
    .lines_i  (dims.lines),
    .base_o   (line_base)
  );

  // clamp to last stored pixel so the address holds past the width
  assign col_sel      = col_inside ? col_idx
                      : (dims.width == '0 ? '0 : dims.width - CW'(1));
  assign addr_o       = line_base + AW'({col_sel, 1'b0});
  assign in_frame_o   = active_q & row_inside & col_inside;
  assign addr_valid_o = in_frame_o & col_first;

  // R2
  addr_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_o[0]);
  // R8
  valid_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> in_frame_o);
  // R9
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !in_frame_o && !frame_start_i && !line_adv_i) |=> $stable(addr_o));
  // R6
  row_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_adv_i && active_q && !frame_start_i && zoom_i && row_first) |=> $stable(line_base));
  // R3
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_adv && !zoom_i && row_inside) |=> col_idx == $past(col_idx) + CW'(1));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!in_frame_o && row_idx == '0));
endmodule

// File: tb/sim_scan_addr_gen.sv
module sim_scan_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, la = 1'b0, pa = 1'b0;
  logic [31:0] base = '0, stride = '0, dim = '0;
  logic        zoom = 1'b0, rev = 1'b0;
  logic [31:0] addr;
  logic        avalid, inframe;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  scan_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .line_adv_i(la),
    .pix_adv_i(pa), .base_addr_i(base), .stride_i(stride), .frame_dim_i(dim),
    .zoom_i(zoom), .rev_scan_i(rev), .addr_o(addr), .addr_valid_o(avalid),
    .in_frame_o(inframe)
  );

  typedef struct packed {
    logic [31:0] b;
    logic [31:0] s;
    logic [10:0] w;
    logic [10:0] h;
    logic        z;
    logic        r;
    logic [7:0]  cols;
    logic [7:0]  rows;
  } cfg_t;

  localparam cfg_t TBL [6] = '{
    '{32'h0000_1000, 32'h40,  11'd4, 11'd3, 1'b0, 1'b0, 8'd6, 8'd5},
    '{32'h0000_2001, 32'h21,  11'd3, 11'd2, 1'b0, 1'b0, 8'd4, 8'd3},
    '{32'h0000_3000, 32'h20,  11'd3, 11'd2, 1'b1, 1'b0, 8'd8, 8'd6},
    '{32'h0000_4000, 32'h30,  11'd4, 11'd3, 1'b0, 1'b1, 8'd5, 8'd4},
    '{32'h0000_5000, 32'h10,  11'd2, 11'd2, 1'b1, 1'b1, 8'd5, 8'd5},
    '{32'hFFFF_FFF0, 32'h100, 11'd3, 11'd2, 1'b0, 1'b0, 8'd4, 8'd3}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic pulse(input logic f, input logic l, input logic p);
    @(negedge clk); fs = f; la = l; pa = p;
    @(negedge clk); fs = 1'b0; la = 1'b0; pa = 1'b0;
    #1;
  endtask

  // junk in unused bits exercises R4
  task automatic start(input cfg_t c);
    @(negedge clk);
    base = c.b; stride = c.s; zoom = c.z; rev = c.r;
    dim = {5'h1f, c.h, 5'h1f, c.w};
    fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    #1;
  endtask

  task automatic run_vec(input cfg_t c);
    logic [31:0] prev, exp;
    int sr, sc, ln;
    bit inf, vld;
    string tag;
    start(c);
    prev = addr;
    for (int r = 0; r < int'(c.rows); r++) begin
      for (int p = 0; p < int'(c.cols); p++) begin
        sr  = c.z ? r / 2 : r;
        sc  = c.z ? p / 2 : p;
        inf = (sc < int'(c.w)) && (sr < int'(c.h));
        vld = inf && (!c.z || (p % 2 == 0));
        if (!inf) tag = (sr >= int'(c.h)) ? "R9" : "R8";
        else if (c.r) tag = "R7";
        else if (c.z) tag = (r % 2 == 1) ? "R6" : "R5";
        else tag = (c.b[0] || c.s[0]) ? "R2" : "R3";
        chk(tag, "in_frame", 32'(inframe), 32'(inf));
        chk(tag, "addr_valid", 32'(avalid), 32'(vld));
        if (inf) begin
          ln  = c.r ? int'(c.h) - 1 - sr : sr;
          exp = {c.b[31:1], 1'b0} + 32'(ln) * {c.s[31:1], 1'b0} + 32'(2 * sc);
          chk(tag, "addr", addr, exp);
        end else if (p > 0) begin
          chk(tag, "addr hold", addr, prev);
        end
        prev = addr;
        if (p < int'(c.cols) - 1) pulse(1'b0, 1'b0, 1'b1);
      end
      pulse(1'b0, 1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg_t c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state and strobes before first frame start
    chk("R10", "addr", addr, 32'h0);
    chk("R10", "in_frame", 32'(inframe), 32'h0);
    chk("R10", "addr_valid", 32'(avalid), 32'h0);
    base = 32'h100; stride = 32'h10; dim = {5'h0, 11'd4, 5'h0, 11'd4};
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R10", "addr after strobes", addr, 32'h0);
    chk("R10", "in_frame after strobes", 32'(inframe), 32'h0);

    foreach (TBL[i]) run_vec(TBL[i]);

    // R11 strobe priority, R1 restart mid-frame
    c = '{32'h800, 32'h80, 11'd8, 11'd4, 1'b0, 1'b0, 8'd0, 8'd0};
    start(c);
    chk("R1", "addr at start", addr, 32'h800);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R3", "addr after two pixels", addr, 32'h804);
    pulse(1'b0, 1'b1, 1'b1);
    chk("R11", "line beats pixel", addr, 32'h880);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R11", "frame beats line", addr, 32'h800);
    chk("R11", "in_frame after restart", 32'(inframe), 32'h1);

    // R1 reverse start lands on last line
    c = '{32'h800, 32'h80, 11'd8, 11'd4, 1'b0, 1'b1, 8'd0, 8'd0};
    start(c);
    chk("R1", "reverse start addr", addr, 32'h980);

    // R12 empty frames
    c = '{32'h600, 32'h20, 11'd0, 11'd2, 1'b0, 1'b0, 8'd0, 8'd0};
    start(c);
    chk("R12", "zero width in_frame", 32'(inframe), 32'h0);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R12", "zero width in_frame next", 32'(inframe), 32'h0);
    c = '{32'h600, 32'h20, 11'd3, 11'd0, 1'b0, 1'b1, 8'd0, 8'd0};
    start(c);
    chk("R12", "zero lines in_frame", 32'(inframe), 32'h0);
    chk("R12", "zero lines addr", addr, 32'h600);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R12", "zero lines after line", 32'(inframe), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule